// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O

This block sits on a simple host bus and provides 24 general-purpose pins in three 8-bit ports, called A, B and C. Port C is treated as two 4-bit halves, and each half has its own direction. The host reaches the block through four consecutive register addresses that start at a base address set by a parameter. Three of these addresses are the port data registers. The fourth is a control register.

A write to the control register carries one of two commands, and bit 7 of the written byte chooses which one.

- **Direction command (bit 7 = 1):** sets the direction of A, B and each half of C. Every output latch is then cleared, so any port that becomes an output starts by driving low.
- **Single-bit command (bit 7 = 0):** sets or clears one bit of port C and leaves the other seven bits of C alone.

Reads return different things depending on the target:

- A port set as output returns its latch.
- A port set as input returns its pins, passed through a synchronizer.
- The control register returns the current direction setting.

The read data is qualified by an output enable, which is high only during a decoded read.

Top module: `pio3_top`

## Requirements
- R1: A register access happens only when `aen_i` is high, a strobe is high and `addr_i` lies in BASE_ADDR to BASE_ADDR+3. Offset 0 selects A, 1 selects B, 2 selects C and 3 selects control. Writes outside these conditions change no state.
- R2: `rdata_oe_o` is high only while a qualified read is in progress (`rd_i` high and `wr_i` low). At all other times `rdata_oe_o` is low and `rdata_o` is 0.
- R3: After reset every port is an input, every latch is 0, every pin output enable is low, and a control read returns 8'h9B.
- R4: A control write with bit 7 set is a direction command. Bit 4 = 1 makes A an input, bit 3 = 1 makes C[7:4] an input, bit 1 = 1 makes B an input and bit 0 = 1 makes C[3:0] an input; a 0 in any of these bits selects output. The per-pin output enables of an output port are all 1, and those of an input port are all 0.
- R5: A direction command clears all 24 output latches to 0 in the same cycle that it updates the directions.
- R6: A control write with bit 7 clear writes bit 0 into port C bit number bits[3:1]. No other C bit, no other port and no direction changes.
- R7: A port read returns the latch for nibbles configured as output. For nibbles configured as input it returns the pins sampled SYNC_STAGES clocks earlier. The two halves of C are chosen separately.
- R8: A control read returns {1, 0, 0, A_in, Chi_in, 0, B_in, Clo_in}.
- R9: A data write to a port set as input updates its latch, which is visible on the `p*_o` pins, while that port's output enables stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Host address |
| aen_i | input | 1 | Address-enable qualifier, active high |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not enabled |
| rdata_oe_o | output | 1 | Read data output enable |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe_o | output | 8 | Port A pin output enables |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe_o | output | 8 | Port B pin output enables |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch out |
| pc_oe_o | output | 8 | Port C pin output enables |

## Verification
The embedded assertions check four properties on every cycle:
- The read-data enable is never high unless a qualified read is present on the raw address, qualifier and strobe ports.
- A direction command leaves every nibble latch at zero on the next cycle.
- A single-bit command changes at most one bit of a nibble.
- The direction register holds its value whenever no write strobe is decoded.

The bench scenarios show the rest:
- The mapping of each control bit to a port.
- The mixed read-back of inputs and latches for all 16 direction combinations.
- The exact bit chosen by each of the 16 set/clear commands.
- That aliased and unqualified addresses are rejected.

// File: rtl/pio3_pkg.sv
package pio3_pkg;
  localparam int PORT_W    = 8;
  localparam int NIB_W     = 4;
  localparam int NUM_NIB   = 6;
  localparam int NUM_REGS  = 4;
  localparam int BIT_IDX_W = $clog2(PORT_W);
  localparam int CMD_BIT   = 7;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } pio3_sel_e;

  // 1 = input
  typedef struct packed {
    logic a_in;
    logic chi_in;
    logic b_in;
    logic clo_in;
  } pio3_dir_t;
endpackage

// File: rtl/pio3_decode.sv
module pio3_decode
  import pio3_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h344
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output pio3_sel_e         sel_o,
  output logic              wr_stb_o,
  output logic              rd_stb_o
);
  logic [ADDR_W:0] ofs;
  logic            hit;

  // offset wraps to a large value below the base
  assign ofs      = {1'b0, addr_i} - {1'b0, BASE_ADDR};
  assign hit      = ofs < (ADDR_W+1)'(NUM_REGS);
  assign sel_o    = pio3_sel_e'(ofs[1:0]);
  assign wr_stb_o = hit & aen_i & wr_i;
  assign rd_stb_o = hit & aen_i & rd_i & ~wr_i;
endmodule

// File: rtl/pio3_ctrl.sv
module pio3_ctrl
  import pio3_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_stb_i,
  input  pio3_sel_e            sel_i,
  input  logic [PORT_W-1:0]    wdata_i,
  output pio3_dir_t            dir_o,
  output logic                 dir_clr_o,
  output logic                 bit_en_o,
  output logic [BIT_IDX_W-1:0] bit_idx_o,
  output logic                 bit_val_o,
  output logic [PORT_W-1:0]    ctl_rd_o
);
  pio3_dir_t dir_q;
  logic      ctl_we;
  logic      unused_wbits;

  assign ctl_we       = wr_stb_i && (sel_i == SEL_CTL);
  assign dir_clr_o    = ctl_we && wdata_i[CMD_BIT];
  assign bit_en_o     = ctl_we && !wdata_i[CMD_BIT];
  assign bit_idx_o    = wdata_i[BIT_IDX_W:1];
  assign bit_val_o    = wdata_i[0];
  assign unused_wbits = ^{wdata_i[6:5], wdata_i[2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '{a_in: 1'b1, chi_in: 1'b1, b_in: 1'b1, clo_in: 1'b1};
    end else if (dir_clr_o) begin
      dir_q <= '{a_in: wdata_i[4], chi_in: wdata_i[3],
                 b_in: wdata_i[1], clo_in: wdata_i[0]};
    end
  end

  assign dir_o    = dir_q;
  assign ctl_rd_o = {1'b1, 2'b00, dir_q.a_in, dir_q.chi_in, 1'b0,
                     dir_q.b_in, dir_q.clo_in};

  assert_dir_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(dir_q));
endmodule

// File: rtl/pio3_nibble.sv
module pio3_nibble
  import pio3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [NIB_W-1:0]         wdata_i,
  input  logic                     clr_i,
  input  logic                     bit_en_i,
  input  logic [$clog2(NIB_W)-1:0] bit_sel_i,
  input  logic                     bit_val_i,
  input  logic                     dir_in_i,
  input  logic [NIB_W-1:0]         pin_i,
  output logic [NIB_W-1:0]         lat_o,
  output logic [NIB_W-1:0]         oe_o,
  output logic [NIB_W-1:0]         rd_o
);
  logic [SYNC_STAGES-1:0][NIB_W-1:0] sync_q;
  logic [NIB_W-1:0]                  lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lat_q <= '0;
    else if (clr_i)    lat_q <= '0;
    else if (wr_en_i)  lat_q <= wdata_i;
    else if (bit_en_i) lat_q[bit_sel_i] <= bit_val_i;
  end

  assign lat_o = lat_q;
  assign oe_o  = {NIB_W{~dir_in_i}};
  assign rd_o  = dir_in_i ? sync_q[SYNC_STAGES-1] : lat_q;

  assert_dir_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (lat_q == '0));

  assert_single_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !wr_en_i && !clr_i) |=> ($countones(lat_q ^ $past(lat_q)) <= 1));
endmodule

// File: rtl/pio3_top.sv
module pio3_top
  import pio3_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h344,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rdata_oe_o,
  input  logic [7:0]        pa_i,
  output logic [7:0]        pa_o,
  output logic [7:0]        pa_oe_o,
  input  logic [7:0]        pb_i,
  output logic [7:0]        pb_o,
  output logic [7:0]        pb_oe_o,
  input  logic [7:0]        pc_i,
  output logic [7:0]        pc_o,
  output logic [7:0]        pc_oe_o
);
  localparam int ALL_W = NUM_NIB * NIB_W;
  localparam logic [ADDR_W:0] BASE_X = {1'b0, BASE_ADDR};

  pio3_sel_e            sel;
  logic                 wr_stb, rd_stb;
  pio3_dir_t            dir;
  logic                 dir_clr, bit_en_any, bit_val;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic [PORT_W-1:0]    ctl_rd;
  logic [NUM_NIB-1:0]   nib_dir;
  logic [ALL_W-1:0]     pin_all, lat_all, oe_all, rd_all;
  logic [PORT_W-1:0]    rd_mux;

  pio3_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_decode (
    .addr_i, .aen_i, .rd_i, .wr_i,
    .sel_o(sel), .wr_stb_o(wr_stb), .rd_stb_o(rd_stb)
  );

  pio3_ctrl i_ctrl (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .sel_i(sel), .wdata_i,
    .dir_o(dir), .dir_clr_o(dir_clr), .bit_en_o(bit_en_any),
    .bit_idx_o(bit_idx), .bit_val_o(bit_val), .ctl_rd_o(ctl_rd)
  );

  // nibble order: A lo, A hi, B lo, B hi, C lo, C hi
  assign nib_dir = {dir.chi_in, dir.clo_in, dir.b_in, dir.b_in, dir.a_in, dir.a_in};
  assign pin_all = {pc_i, pb_i, pa_i};

  for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
    localparam int PORT = g / 2;
    localparam int HALF = g % 2;
    logic wr_en, bit_en;

    assign wr_en = wr_stb && (sel == pio3_sel_e'(2'(PORT)));
    if (PORT == 2) begin : g_c
      assign bit_en = bit_en_any && (bit_idx[BIT_IDX_W-1] == 1'(HALF));
    end else begin : g_ab
      assign bit_en = 1'b0;
    end

    pio3_nibble #(.SYNC_STAGES(SYNC_STAGES)) i_nibble (
      .clk_i, .rst_ni,
      .wr_en_i(wr_en),
      .wdata_i(wdata_i[HALF*NIB_W +: NIB_W]),
      .clr_i(dir_clr),
      .bit_en_i(bit_en),
      .bit_sel_i(bit_idx[$clog2(NIB_W)-1:0]),
      .bit_val_i(bit_val),
      .dir_in_i(nib_dir[g]),
      .pin_i(pin_all[g*NIB_W +: NIB_W]),
      .lat_o(lat_all[g*NIB_W +: NIB_W]),
      .oe_o(oe_all[g*NIB_W +: NIB_W]),
      .rd_o(rd_all[g*NIB_W +: NIB_W])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_A:   rd_mux = rd_all[7:0];
      SEL_B:   rd_mux = rd_all[15:8];
      SEL_C:   rd_mux = rd_all[23:16];
      default: rd_mux = ctl_rd;
    endcase
  end

  assign rdata_oe_o = rd_stb;
  assign rdata_o    = rd_stb ? rd_mux : '0;

  assign {pc_o, pb_o, pa_o}          = lat_all;
  assign {pc_oe_o, pb_oe_o, pa_oe_o} = oe_all;

  assert_oe_qualified_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> (aen_i && rd_i && !wr_i &&
                    ({1'b0, addr_i} >= BASE_X) && ({1'b0, addr_i} < BASE_X + 4)));
endmodule

// File: tb/test_pio3_top.sv
`timescale 1ns/1ps
module test_pio3_top;
  localparam logic [9:0] BASE = 10'h344;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic       aen = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pio3_top i_pio3_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .aen_i(aen), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [9:0] a, input logic en, input logic w, input logic r,
                     input logic [7:0] d, output logic [7:0] q, output logic oe);
    @(negedge clk);
    addr = a; aen = en; wr = w; rd = r; wdata = d;
    #2;
    q = rdata; oe = rdata_oe;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; aen = 1'b0;
  endtask

  task automatic bwr(input int off, input logic [7:0] d);
    logic [7:0] q; logic oe;
    cyc(BASE + 10'(off), 1'b1, 1'b1, 1'b0, d, q, oe);
  endtask

  task automatic brd(input int off, output logic [7:0] q);
    logic oe;
    cyc(BASE + 10'(off), 1'b1, 1'b0, 1'b1, 8'h00, q, oe);
    chk("R2 oe on qualified read", 32'(oe), 32'd1);
  endtask

  function automatic logic [7:0] dir_word(input logic [3:0] cfg);
    return {1'b1, 2'b00, cfg[3], cfg[2], 1'b0, cfg[1], cfg[0]};
  endfunction

  function automatic logic [7:0] mix(input logic in_hi, input logic in_lo,
                                     input logic [7:0] pins, input logic [7:0] lat);
    return {in_hi ? pins[7:4] : lat[7:4], in_lo ? pins[3:0] : lat[3:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] q, la, lb, lc, c_mod;
    logic oe;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    chk("R3 oe after reset", {8'h0, pc_oe, pb_oe, pa_oe}, 32'h0);
    chk("R3 latches after reset", {8'h0, pc_o, pb_o, pa_o}, 32'h0);
    chk("R2 idle oe", 32'(rdata_oe), 32'd0);
    chk("R2 idle data", 32'(rdata), 32'd0);
    brd(3, q);
    chk("R3 control after reset", 32'(q), 32'h9B);

    // direction sweep: cfg = {A, Chi, B, Clo}, 1 = input
    for (int k = 0; k < 16; k++) begin
      logic [3:0] cfg;
      cfg = 4'(k);
      bwr(0, 8'hFF); bwr(1, 8'hFF); bwr(2, 8'hFF);
      bwr(3, dir_word(cfg));
      chk("R5 latches cleared", {8'h0, pc_o, pb_o, pa_o}, 32'h0);
      chk("R4 A oe", 32'(pa_oe), cfg[3] ? 32'h00 : 32'hFF);
      chk("R4 B oe", 32'(pb_oe), cfg[1] ? 32'h00 : 32'hFF);
      chk("R4 C oe", 32'(pc_oe), {24'h0, cfg[2] ? 4'h0 : 4'hF, cfg[0] ? 4'h0 : 4'hF});
      brd(3, q);
      chk("R8 control readback", 32'(q), 32'(dir_word(cfg)));

      pa_i = 8'(k * 17) ^ 8'hA5;
      pb_i = ~8'(k * 29);
      pc_i = {cfg, ~cfg} ^ 8'h36;
      la = 8'h3C ^ 8'(k);
      lb = 8'hC3 + 8'(k * 7);
      lc = 8'h5A ^ 8'(k << 3);
      bwr(0, la); bwr(1, lb); bwr(2, lc);
      repeat (3) @(negedge clk);
      chk("R9 A latch visible", 32'(pa_o), 32'(la));
      chk("R9 B latch visible", 32'(pb_o), 32'(lb));
      chk("R9 C latch visible", 32'(pc_o), 32'(lc));
      chk("R9 A oe unchanged", 32'(pa_oe), cfg[3] ? 32'h00 : 32'hFF);
      brd(0, q); chk("R7 A read", 32'(q), 32'(mix(cfg[3], cfg[3], pa_i, la)));
      brd(1, q); chk("R7 B read", 32'(q), 32'(mix(cfg[1], cfg[1], pb_i, lb)));
      brd(2, q); chk("R7 C read", 32'(q), 32'(mix(cfg[2], cfg[0], pc_i, lc)));
    end

    // single-bit commands on port C
    bwr(3, 8'h80);
    bwr(0, 8'h11); bwr(1, 8'h22);
    c_mod = 8'hA5;
    bwr(2, c_mod);
    for (int i = 0; i < 8; i++) begin
      for (int v = 0; v < 2; v++) begin
        bwr(3, {4'b0000, 3'(i), 1'(v)});
        c_mod[i] = 1'(v);
        chk("R6 C after bit cmd", 32'(pc_o), 32'(c_mod));
        chk("R6 A/B untouched", {16'h0, pb_o, pa_o}, 32'h2211);
      end
      brd(2, q);
      chk("R7 C read after bit cmd", 32'(q), 32'(c_mod));
    end
    brd(3, q);
    chk("R6 directions untouched", 32'(q), 32'h80);

    // R1 decode qualification
    bwr(0, 8'h12);
    cyc(BASE, 1'b0, 1'b1, 1'b0, 8'hEE, q, oe);
    chk("R1 write with aen low", 32'(pa_o), 32'h12);
    cyc(BASE + 10'd4, 1'b1, 1'b1, 1'b0, 8'hEE, q, oe);
    chk("R1 write above range", 32'(pa_o), 32'h12);
    cyc(BASE - 10'd1, 1'b1, 1'b1, 1'b0, 8'h9B, q, oe);
    cyc(BASE + 10'd7, 1'b1, 1'b1, 1'b0, 8'h9B, q, oe);
    chk("R1 alias writes ignored", {pc_oe, pb_oe, pa_oe, 8'h0}, 32'hFFFFFF00);
    brd(3, q);
    chk("R1 control unchanged", 32'(q), 32'h80);

    // R2 read enable qualification
    cyc(BASE, 1'b0, 1'b0, 1'b1, 8'h00, q, oe);
    chk("R2 read with aen low oe", 32'(oe), 32'd0);
    chk("R2 read with aen low data", 32'(q), 32'd0);
    cyc(BASE + 10'd5, 1'b1, 1'b0, 1'b1, 8'h00, q, oe);
    chk("R2 read out of range oe", 32'(oe), 32'd0);
    cyc(BASE + 10'd1, 1'b1, 1'b1, 1'b1, 8'h77, q, oe);
    chk("R2 read during write oe", 32'(oe), 32'd0);
    chk("R1 write with both strobes", 32'(pb_o), 32'h77);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule